// File: doc/BRIEF.md
# Dual Stack Unit in Shared Nibble RAM

This block keeps two independent stacks inside a single RAM of 4-bit words. The first is an operand stack of 4-bit elements. Its newest element sits in a register (the top-of-stack register) that works like an accumulator. Older elements are spilled to RAM at the operand pointer. The second stack holds 12-bit entries, such as return addresses or loop counts. Each entry is spread over three consecutive nibbles inside a slot of four RAM words, and the return pointer moves by four per entry.

A sequencer drives one operation code per clock. The block offers both the top element and the element beneath it to an outside ALU, and writes an ALU result back with a combined pop. Two transfer operations move a value between the operand top and the return top. The user chooses where each stack lives, and how far it may grow, with the start pointer and limit values presented while reset is held. A push that would take a pointer beyond its limit is refused, and an overflow flag is raised for one cycle.

Top module: `dual_stack_unit`

## Requirements
- R1: While `rst_n` is low on a clock edge, `tos` becomes 0, `sp` takes `sp_init`, `rp` takes `rp_init` with its two low bits cleared, the limits are captured (`r_limit` with its two low bits cleared), and both overflow flags become 0. `rp` always has its two low bits at 0.
- R2: `op`=1 (operand push): unless refused, after the edge `sp` is one higher, `tos` equals `push_data` and `nos` equals the previous `tos`.
- R3: `op`=2 (operand pop): after the edge `tos` equals the previous `nos` and `sp` is one lower.
- R4: `op`=7 (ALU write-back): after the edge `tos` equals `alu_result` and `sp` is one lower, so the old second element is consumed.
- R5: `op`=3 (return push): unless refused, after the edge `rp` is four higher and `ret_top` equals `ret_wdata`. Bits 3:0 are stored at `rp`, 7:4 at `rp`+1, and 11:8 at `rp`+2.
- R6: `op`=4 (return pop): after the edge `rp` is four lower and `ret_top` shows the entry beneath.
- R7: `op`=5 (operand to return): unless refused, `tos` zero-extended to 12 bits is pushed on the return stack and the operand stack is popped, in the same cycle.
- R8: `op`=6 (return to operand): unless refused, bits 3:0 of `ret_top` are pushed on the operand stack and the return stack is popped, in the same cycle.
- R9: An operand-side push (`op` 1 or 6) when `sp` equals the captured operand limit changes no state, and `e_ovf` is 1 for the following cycle only.
- R10: A return-side push (`op` 3 or 5) when `rp` equals the captured return limit changes no state, and `r_ovf` is 1 for the following cycle only.
- R11: `op`=0 changes no state. When the two stacks occupy disjoint RAM regions, operations on one stack leave the other stack's visible top unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; captures the start pointers and limits |
| sp_init | input | 8 | Operand pointer start value |
| rp_init | input | 8 | Return pointer start value (low two bits ignored) |
| e_limit | input | 8 | Highest operand pointer value a push may leave |
| r_limit | input | 8 | Highest return pointer value a push may leave (low two bits ignored) |
| op | input | 3 | Operation code: 0 hold, 1 operand push, 2 operand pop, 3 return push, 4 return pop, 5 operand to return, 6 return to operand, 7 ALU write-back |
| push_data | input | 4 | Value for an operand push |
| alu_result | input | 4 | Value for an ALU write-back |
| ret_wdata | input | 12 | Value for a return push |
| tos | output | 4 | Top operand element |
| nos | output | 4 | Second operand element (RAM at `sp`) |
| ret_top | output | 12 | Top return entry (RAM at `rp`..`rp`+2) |
| sp | output | 8 | Operand pointer |
| rp | output | 8 | Return pointer |
| e_ovf | output | 1 | One-cycle operand overflow flag |
| r_ovf | output | 1 | One-cycle return overflow flag |

## Verification
The hardest cases to reach are the transfers refused at a limit: a return-to-operand move when the operand stack is full and the return stack still holds entries, and an operand-to-return move when the return stack is full. In both cases nothing may change on either side. The bench reaches these states by filling one stack to its captured limit while the other stack is partly loaded. It then issues the transfer and compares both stack tops, both pointers and both flags with a model that keeps plain arrays per stack. It sweeps every nibble value through the operand stack over several fill-and-drain rounds, and it places the two stacks in separate RAM regions so that any disturbance of one stack by the other shows at the ports.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
    localparam int DEF_AW   = 8;
    localparam int DEF_NW   = 4;
    localparam int DEF_RNIB = 3;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_EPUSH = 3'd1,
        OP_EPOP  = 3'd2,
        OP_RPUSH = 3'd3,
        OP_RPOP  = 3'd4,
        OP_E2R   = 3'd5,
        OP_R2E   = 3'd6,
        OP_ALUWB = 3'd7
    } dsu_op_e;
endpackage

// File: rtl/dsu_ptr_step.sv
module dsu_ptr_step #(
    parameter int AW   = 8,
    parameter int STEP = 1
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] inc,
    output logic [AW-1:0] dec,
    output logic          full
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    assign inc  = ptr + STEP_V;
    assign dec  = ptr - STEP_V;
    assign full = (ptr == limit);
endmodule

// File: rtl/dsu_nib_ram.sv
module dsu_nib_ram #(
    parameter int AW  = 8,
    parameter int NW  = 4,
    parameter int NWR = 4,
    parameter int NRD = 4
) (
    input  logic          clk,
    input  logic          we    [NWR],
    input  logic [AW-1:0] waddr [NWR],
    input  logic [NW-1:0] wdata [NWR],
    input  logic [AW-1:0] raddr [NRD],
    output logic [NW-1:0] rdata [NRD]
);
    localparam int DEPTH = 1 << AW;

    logic [NW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NWR; i++) begin
            if (we[i]) begin
                mem[waddr[i]] <= wdata[i];
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end
endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit
    import dsu_pkg::*;
#(
    parameter int AW   = DEF_AW,
    parameter int NW   = DEF_NW,
    parameter int RNIB = DEF_RNIB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        sp_init,
    input  logic [AW-1:0]        rp_init,
    input  logic [AW-1:0]        e_limit,
    input  logic [AW-1:0]        r_limit,
    input  logic [2:0]           op,
    input  logic [NW-1:0]        push_data,
    input  logic [NW-1:0]        alu_result,
    input  logic [RNIB*NW-1:0]   ret_wdata,
    output logic [NW-1:0]        tos,
    output logic [NW-1:0]        nos,
    output logic [RNIB*NW-1:0]   ret_top,
    output logic [AW-1:0]        sp,
    output logic [AW-1:0]        rp,
    output logic                 e_ovf,
    output logic                 r_ovf
);
    localparam int            RW    = RNIB * NW;
    localparam int            RSTEP = 1 << $clog2(RNIB);
    localparam logic [AW-1:0] RMASK = ~AW'(RSTEP - 1);
    localparam int            NWR   = RNIB + 1;
    localparam int            NRD   = RNIB + 1;

    typedef struct packed {
        logic [NW-1:0] tos;
        logic [AW-1:0] sp;
        logic [AW-1:0] rp;
        logic [AW-1:0] elim;
        logic [AW-1:0] rlim;
        logic          eovf;
        logic          rovf;
    } dsu_state_t;

    dsu_state_t q, d;

    logic [AW-1:0] e_inc, e_dec, r_inc, r_dec;
    logic          e_full, r_full;

    dsu_ptr_step #(.AW(AW), .STEP(1)) u_eptr (
        .ptr(q.sp), .limit(q.elim), .inc(e_inc), .dec(e_dec), .full(e_full)
    );

    dsu_ptr_step #(.AW(AW), .STEP(RSTEP)) u_rptr (
        .ptr(q.rp), .limit(q.rlim), .inc(r_inc), .dec(r_dec), .full(r_full)
    );

    logic          e_we;
    logic          r_we;
    logic [RW-1:0] r_wdata;

    logic          we_a [NWR];
    logic [AW-1:0] wa_a [NWR];
    logic [NW-1:0] wd_a [NWR];
    logic [AW-1:0] ra_a [NRD];
    logic [NW-1:0] rd_a [NRD];

    assign we_a[0] = e_we;
    assign wa_a[0] = e_inc;
    assign wd_a[0] = q.tos;
    assign ra_a[0] = q.sp;
    assign nos     = rd_a[0];

    for (genvar k = 1; k <= RNIB; k++) begin : g_rnib
        assign we_a[k] = r_we;
        assign wa_a[k] = r_inc + AW'(k - 1);
        assign wd_a[k] = r_wdata[(k-1)*NW +: NW];
        assign ra_a[k] = q.rp + AW'(k - 1);
        assign ret_top[(k-1)*NW +: NW] = rd_a[k];
    end

    dsu_nib_ram #(.AW(AW), .NW(NW), .NWR(NWR), .NRD(NRD)) u_ram (
        .clk(clk), .we(we_a), .waddr(wa_a), .wdata(wd_a),
        .raddr(ra_a), .rdata(rd_a)
    );

    always_comb begin
        d       = q;
        d.eovf  = 1'b0;
        d.rovf  = 1'b0;
        e_we    = 1'b0;
        r_we    = 1'b0;
        r_wdata = ret_wdata;
        unique case (dsu_op_e'(op))
            OP_EPUSH: begin
                if (e_full) begin
                    d.eovf = 1'b1;
                end else begin
                    e_we  = 1'b1;
                    d.sp  = e_inc;
                    d.tos = push_data;
                end
            end
            OP_EPOP: begin
                d.tos = nos;
                d.sp  = e_dec;
            end
            OP_ALUWB: begin
                d.tos = alu_result;
                d.sp  = e_dec;
            end
            OP_RPUSH: begin
                if (r_full) begin
                    d.rovf = 1'b1;
                end else begin
                    r_we = 1'b1;
                    d.rp = r_inc;
                end
            end
            OP_RPOP: begin
                d.rp = r_dec;
            end
            OP_E2R: begin
                r_wdata = RW'(q.tos);
                if (r_full) begin
                    d.rovf = 1'b1;
                end else begin
                    r_we  = 1'b1;
                    d.rp  = r_inc;
                    d.tos = nos;
                    d.sp  = e_dec;
                end
            end
            OP_R2E: begin
                if (e_full) begin
                    d.eovf = 1'b1;
                end else begin
                    e_we  = 1'b1;
                    d.sp  = e_inc;
                    d.tos = ret_top[NW-1:0];
                    d.rp  = r_dec;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.tos  <= '0;
            q.sp   <= sp_init;
            q.rp   <= rp_init & RMASK;
            q.elim <= e_limit;
            q.rlim <= r_limit & RMASK;
            q.eovf <= 1'b0;
            q.rovf <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tos   = q.tos;
    assign sp    = q.sp;
    assign rp    = q.rp;
    assign e_ovf = q.eovf;
    assign r_ovf = q.rovf;
endmodule

// File: rtl/dsu_chk.sv
module dsu_chk
    import dsu_pkg::*;
#(
    parameter int AW   = 8,
    parameter int NW   = 4,
    parameter int RNIB = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         op,
    input logic [NW-1:0]      push_data,
    input logic [NW-1:0]      alu_result,
    input logic [RNIB*NW-1:0] ret_wdata,
    input logic [NW-1:0]      tos,
    input logic [NW-1:0]      nos,
    input logic [RNIB*NW-1:0] ret_top,
    input logic [AW-1:0]      sp,
    input logic [AW-1:0]      rp,
    input logic               e_ovf,
    input logic               r_ovf,
    input logic               e_full,
    input logic               r_full
);
    localparam int RSTEP = 1 << $clog2(RNIB);

    // R1
    rp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp & AW'(RSTEP - 1)) == '0);

    // R2
    epush_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EPUSH && !e_full) |=>
        (sp == AW'($past(sp) + 1) && tos == $past(push_data) && nos == $past(tos)));

    // R3
    epop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EPOP) |=> (tos == $past(nos) && sp == AW'($past(sp) - 1)));

    // R4
    aluwb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ALUWB) |=> (tos == $past(alu_result) && sp == AW'($past(sp) - 1)));

    // R5
    rpush_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RPUSH && !r_full) |=>
        (rp == AW'($past(rp) + RSTEP) && ret_top == $past(ret_wdata)));

    // R6
    rpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RPOP) |=> (rp == AW'($past(rp) - RSTEP)));

    // R7
    e2r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_E2R && !r_full) |=>
        (ret_top == (RNIB*NW)'($past(tos)) && tos == $past(nos)));

    // R8
    r2e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_R2E && !e_full) |=>
        (tos == $past(ret_top[NW-1:0]) && nos == $past(tos)));

    // R9
    e_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_EPUSH || op == OP_R2E) && e_full) |=>
        (e_ovf && $stable(sp) && $stable(rp) && $stable(tos)));

    // R10
    r_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_RPUSH || op == OP_E2R) && r_full) |=>
        (r_ovf && $stable(sp) && $stable(rp) && $stable(tos)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP) |=> ($stable(sp) && $stable(rp) && $stable(tos) && !e_ovf && !r_ovf));
endmodule

bind dual_stack_unit dsu_chk #(.AW(AW), .NW(NW), .RNIB(RNIB)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .push_data(push_data),
    .alu_result(alu_result), .ret_wdata(ret_wdata), .tos(tos), .nos(nos),
    .ret_top(ret_top), .sp(sp), .rp(rp), .e_ovf(e_ovf), .r_ovf(r_ovf),
    .e_full(e_full), .r_full(r_full)
);

// File: tb/tb_dual_stack_unit.sv
module tb_dual_stack_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SP0   = 8'h40;
    localparam logic [7:0] ELIM  = 8'h47;
    localparam logic [7:0] RPIN  = 8'h83;
    localparam logic [7:0] RP0   = 8'h80;
    localparam logic [7:0] RLIN  = 8'h8E;
    localparam int E_CAP = 7;
    localparam int R_CAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [3:0]  push_data = 4'd0, alu_result = 4'd0;
    logic [11:0] ret_wdata = 12'd0;
    logic [3:0]  tos, nos;
    logic [11:0] ret_top;
    logic [7:0]  sp, rp;
    logic        e_ovf, r_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_stack_unit dut (
        .clk(clk), .rst_n(rst_n), .sp_init(SP0), .rp_init(RPIN),
        .e_limit(ELIM), .r_limit(RLIN), .op(op), .push_data(push_data),
        .alu_result(alu_result), .ret_wdata(ret_wdata), .tos(tos), .nos(nos),
        .ret_top(ret_top), .sp(sp), .rp(rp), .e_ovf(e_ovf), .r_ovf(r_ovf)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int          ed = 0, rd = 0;
    logic [3:0]  mt = 4'd0;
    logic [3:0]  es [16];
    logic [11:0] rs [16];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] o, input logic [3:0] pd,
                       input logic [3:0] ar, input logic [11:0] rw,
                       input string tag);
        logic eo, ro;
        eo = 1'b0; ro = 1'b0;
        case (o)
            3'd1: if (ed == E_CAP) eo = 1'b1;
                  else begin es[ed] = mt; ed++; mt = pd; end
            3'd2: begin mt = es[ed-1]; ed--; end
            3'd7: begin mt = ar; ed--; end
            3'd3: if (rd == R_CAP) ro = 1'b1;
                  else begin rs[rd] = rw; rd++; end
            3'd4: rd--;
            3'd5: if (rd == R_CAP) ro = 1'b1;
                  else begin rs[rd] = {8'h00, mt}; rd++; mt = es[ed-1]; ed--; end
            3'd6: if (ed == E_CAP) eo = 1'b1;
                  else begin es[ed] = mt; ed++; mt = rs[rd-1][3:0]; rd--; end
            default: ;
        endcase
        op = o; push_data = pd; alu_result = ar; ret_wdata = rw;
        @(posedge clk);
        @(negedge clk);
        op = 3'd0;
        chk(tag, "tos", 32'(tos), 32'(mt));
        chk(tag, "sp", 32'(sp), 32'(8'(SP0 + ed)));
        chk(tag, "rp", 32'(rp), 32'(8'(RP0 + 4*rd)));
        chk("R9", "e_ovf", 32'(e_ovf), 32'(eo));
        chk("R10", "r_ovf", 32'(r_ovf), 32'(ro));
        if (ed > 0) chk(tag, "nos", 32'(nos), 32'(es[ed-1]));
        if (rd > 0) chk((o == 3'd1 || o == 3'd2 || o == 3'd7) ? "R11" : tag,
                        "ret_top", 32'(ret_top), 32'(rs[rd-1]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tos", 32'(tos), 32'd0);
        chk("R1", "sp", 32'(sp), 32'(SP0));
        chk("R1", "rp", 32'(rp), 32'(RP0));
        chk("R1", "e_ovf", 32'(e_ovf), 32'd0);
        chk("R1", "r_ovf", 32'(r_ovf), 32'd0);
        run(3'd0, 4'd5, 4'd5, 12'h5A5, "R11");

        // R2/R3/R4/R9: fill-and-drain sweeps over all nibble values
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < E_CAP; i++)
                run(3'd1, 4'((r*7 + i*3) & 15), 4'd0, 12'd0, "R2");
            run(3'd1, 4'hF, 4'd0, 12'd0, "R9");
            run(3'd1, 4'h0, 4'd0, 12'd0, "R9");
            run(3'd7, 4'd0, 4'((mt + es[ed-1]) & 15), 12'd0, "R4");
            run(3'd7, 4'd0, 4'((mt ^ es[ed-1]) & 15), 12'd0, "R4");
            while (ed > 0) run(3'd2, 4'd0, 4'd0, 12'd0, "R3");
        end

        // R5/R6/R10: return stack fill and drain
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < R_CAP; i++)
                run(3'd3, 4'd0, 4'd0, 12'((r*12'h3A7 + i*12'h15C) & 12'hFFF), "R5");
            run(3'd3, 4'd0, 4'd0, 12'hABC, "R10");
            run(3'd0, 4'd0, 4'd0, 12'd0, "R11");
            while (rd > 0) run(3'd4, 4'd0, 4'd0, 12'd0, "R6");
        end

        // R7/R8 transfers with both stacks partly loaded
        run(3'd3, 4'd0, 4'd0, 12'h9D2, "R5");
        for (int i = 0; i < 4; i++) run(3'd1, 4'(i + 9), 4'd0, 12'd0, "R11");
        run(3'd5, 4'd0, 4'd0, 12'd0, "R7");
        run(3'd5, 4'd0, 4'd0, 12'd0, "R7");
        run(3'd5, 4'd0, 4'd0, 12'd0, "R10");
        run(3'd6, 4'd0, 4'd0, 12'd0, "R8");
        run(3'd6, 4'd0, 4'd0, 12'd0, "R8");
        run(3'd5, 4'd0, 4'd0, 12'd0, "R7");
        while (ed < E_CAP) run(3'd1, 4'(ed + 2), 4'd0, 12'd0, "R2");
        run(3'd6, 4'd0, 4'd0, 12'd0, "R9");
        run(3'd2, 4'd0, 4'd0, 12'd0, "R3");
        run(3'd6, 4'd0, 4'd0, 12'd0, "R8");
        run(3'd6, 4'd0, 4'd0, 12'd0, "R9");
        run(3'd4, 4'd0, 4'd0, 12'd0, "R6");
        run(3'd0, 4'd0, 4'd0, 12'd0, "R11");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule